// File: doc/BRIEF.md
# Hardwired Accumulator Processor Core

This block is a small 16-bit processor built around one accumulator and a one-bit extension flag used as the carry. A 4-bit step counter walks each instruction through a fixed list of register transfers. Three steps fetch and decode every instruction. The remaining steps perform the operation, and the final step of each instruction returns the counter to step zero. The core holds a word-addressed memory of 2^12 sixteen-bit words, and that memory stores both program and data. A test harness fills the memory through a preload port while the core is stopped.

Each instruction word carries an indirect flag, a three-bit operation field and a twelve-bit address. Operation values 0 to 6 act on memory: logical AND, add, load, store, jump, call with the return address saved in memory, and increment-and-skip-if-zero. Operation value 7 is an extension group. In that group each low bit selects one accumulator or flag operation, one of four conditional skips, or the halt. Every memory operation starts its work on the same step, so an indirect operand costs no extra cycles. A run starts with the start input and stops at a halt instruction.

Top module: `acc_cpu_core`

## Requirements
- R1: Reset sets the program counter, accumulator and extension flag to 0 and leaves the core stopped (`halted` = 1).
- R2: While the core is stopped, the program counter, accumulator and flag hold their values. A one-cycle `start` pulse resumes execution at the current program counter.
- R3: Bit 15 of an instruction is the indirect flag, bits 14:12 are the operation and bits 11:0 are the address. Operation 7 with bit 15 = 1 (for example F800, F080) is a no-op that takes 4 cycles.
- R4: Instruction cost in cycles: every extension-group instruction 4; store and jump 5; AND, add, load and call 6; increment-and-skip 7. Indirect operands add nothing.
- R5: AND (op 0) ANDs the memory word into the accumulator. Add (op 1) adds it and puts the carry-out in the flag. Load (op 2) copies it. AND and load leave the flag unchanged.
- R6: Store (op 3) writes the accumulator to the memory word at the effective address.
- R7: Jump (op 4) loads the program counter with the effective address. Call (op 5) writes the return address into the word at the effective address and continues at the effective address plus 1.
- R8: Increment-and-skip (op 6) adds 1 to the memory word. When the new value is zero, the next instruction is skipped.
- R9: With bit 15 = 1, the effective address is bits 11:0 of the word at the instruction's address field.
- R10: Extension codes 7800 clear the accumulator, 7400 clear the flag, 7200 invert the accumulator, 7100 invert the flag and 7020 increment the accumulator.
- R11: 7080 rotates the 17-bit pair {flag, accumulator} right: the flag enters bit 15 and bit 0 goes to the flag. 7040 rotates it left: the flag enters bit 0 and bit 15 goes to the flag.
- R12: Skip codes: 7010 skips when accumulator bit 15 is 0, 7008 when it is 1, 7004 when the accumulator is zero, and 7002 when the flag is zero.
- R13: 7001 stops the core. `halted` rises and the program counter points to the word after the halt.
- R14: A cycle with `load_we` = 1 writes `load_data` into the memory word at `load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sets the run flip-flop |
| load_we | input | 1 | Preload write enable |
| load_addr | input | 12 | Preload word address |
| load_data | input | 16 | Preload word value |
| halted | output | 1 | High while the core is stopped |
| dbg_pc | output | 12 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_e | output | 1 | Extension (carry) flag |

## Verification
A wrong step count or a step counter that fails to clear changes how long the core runs before `halted` rises, so the bench measures the run length of every program in cycles. A wrong accumulator or flag reaches `dbg_ac` and `dbg_e` at the next halt. A wrong memory write or effective address shows up only when a later load reads that word back, so directed programs follow each write with a read. A wrong skip or branch moves the final program counter away from its expected value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_JMP = 3'd4,
        OP_CALL = 3'd5,
        OP_INCSKIP = 3'd6,
        OP_EXT = 3'd7
    } opcode_e;

    // bit positions inside the extension-group selector field
    localparam int XB_CLRAC  = 11;
    localparam int XB_CLRE   = 10;
    localparam int XB_INVAC  = 9;
    localparam int XB_INVE   = 8;
    localparam int XB_ROR    = 7;
    localparam int XB_ROL    = 6;
    localparam int XB_INCAC  = 5;
    localparam int XB_SKPOS  = 4;
    localparam int XB_SKNEG  = 3;
    localparam int XB_SKZERO = 2;
    localparam int XB_SKEZ   = 1;
    localparam int XB_STOP   = 0;
    localparam int XB_COUNT  = 12;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata = words_q[raddr];

endmodule

// File: rtl/acc_cpu_timer.sv
module acc_cpu_timer #(
    parameter int SC_W  = 4,
    parameter int NSTEP = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    output logic [NSTEP-1:0] step_o
);
    logic [SC_W-1:0] sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (clr_i) begin
            sc_d = '0;
        end else if (run_i) begin
            sc_d = sc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        assign step_o[g] = run_i && (sc_q == SC_W'(g));
    end

    // R4
    sc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q < SC_W'(NSTEP));

    // R2
    idle_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (sc_q == '0));

endmodule

// File: rtl/acc_cpu_extops.sv
module acc_cpu_extops
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                ac_i,
    input  logic                e_i,
    input  logic [XB_COUNT-1:0] sel_i,
    input  logic [DW-1:0]       acc_i,
    output logic [DW-1:0]       acc_o,
    output logic                e_o,
    output logic                skip_o,
    output logic                stop_o
);
    logic [DW-1:0] a;
    logic          f;
    logic          unused_ac;

    assign unused_ac = ac_i;

    always_comb begin
        a = acc_i;
        f = e_i;
        if (sel_i[XB_CLRAC]) a = '0;
        if (sel_i[XB_CLRE])  f = 1'b0;
        if (sel_i[XB_INVAC]) a = ~a;
        if (sel_i[XB_INVE])  f = ~f;
        if (sel_i[XB_ROR])   {a, f} = {f, a};
        if (sel_i[XB_ROL])   {f, a} = {a, f};
        if (sel_i[XB_INCAC]) a = a + 1'b1;
        acc_o = a;
        e_o   = f;
        skip_o = (sel_i[XB_SKPOS]  && !acc_i[DW-1])
              || (sel_i[XB_SKNEG]  &&  acc_i[DW-1])
              || (sel_i[XB_SKZERO] && (acc_i == '0))
              || (sel_i[XB_SKEZ]   && !e_i);
        stop_o = sel_i[XB_STOP];
    end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 12,
    parameter int SC_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic          halted,
    output logic [AW-1:0] dbg_pc,
    output logic [DW-1:0] dbg_ac,
    output logic          dbg_e
);
    localparam int NSTEP = 7;
    localparam int OP_HI = DW - 2;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] ar;
        logic [DW-1:0] ir;
        logic [DW-1:0] dr;
        logic [DW-1:0] ac;
        logic          e;
        logic          ind;
        logic          run;
    } core_t;

    core_t core_d, core_q;

    logic [NSTEP-1:0] step;
    logic             sc_clr;
    logic             mem_we;
    logic [DW-1:0]    mem_wdata;
    logic [DW-1:0]    rdata;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [DW-1:0]    ram_wdata;
    logic [DW-1:0]    x_acc;
    logic             x_e;
    logic             x_skip;
    logic             x_stop;
    opcode_e          op;
    logic [DW:0]      sum;

    assign op = opcode_e'(core_q.ir[OP_HI -: 3]);
    assign sum = {1'b0, core_q.ac} + {1'b0, core_q.dr};

    acc_cpu_timer #(.SC_W(SC_W), .NSTEP(NSTEP)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (core_q.run),
        .clr_i  (sc_clr),
        .step_o (step)
    );

    assign ram_we    = load_we | mem_we;
    assign ram_waddr = load_we ? load_addr : core_q.ar;
    assign ram_wdata = load_we ? load_data : mem_wdata;

    acc_cpu_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (core_q.ar),
        .rdata (rdata)
    );

    acc_cpu_extops #(.DW(DW)) u_ext (
        .ac_i   (core_q.run),
        .e_i    (core_q.e),
        .sel_i  (core_q.ir[XB_COUNT-1:0]),
        .acc_i  (core_q.ac),
        .acc_o  (x_acc),
        .e_o    (x_e),
        .skip_o (x_skip),
        .stop_o (x_stop)
    );

    always_comb begin
        core_d    = core_q;
        sc_clr    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = core_q.ac;
        if (!core_q.run) begin
            if (start) core_d.run = 1'b1;
        end else if (step[0]) begin
            core_d.ar = core_q.pc;
        end else if (step[1]) begin
            core_d.ir = rdata;
            core_d.pc = core_q.pc + 1'b1;
        end else if (step[2]) begin
            core_d.ar  = core_q.ir[AW-1:0];
            core_d.ind = core_q.ir[DW-1];
        end else if (step[3]) begin
            if (op == OP_EXT) begin
                sc_clr = 1'b1;
                if (!core_q.ind) begin
                    core_d.ac = x_acc;
                    core_d.e  = x_e;
                    if (x_skip) core_d.pc = core_q.pc + 1'b1;
                    if (x_stop) core_d.run = 1'b0;
                end
            end else if (core_q.ind) begin
                core_d.ar = rdata[AW-1:0];
            end
        end else if (step[4]) begin
            case (op)
                OP_AND, OP_ADD, OP_LDA, OP_INCSKIP: core_d.dr = rdata;
                OP_STA: begin
                    mem_we = 1'b1;
                    sc_clr = 1'b1;
                end
                OP_JMP: begin
                    core_d.pc = core_q.ar;
                    sc_clr    = 1'b1;
                end
                OP_CALL: begin
                    mem_we    = 1'b1;
                    mem_wdata = {{(DW-AW){1'b0}}, core_q.pc};
                    core_d.ar = core_q.ar + 1'b1;
                end
                default: sc_clr = 1'b1;
            endcase
        end else if (step[5]) begin
            sc_clr = 1'b1;
            case (op)
                OP_AND: core_d.ac = core_q.ac & core_q.dr;
                OP_ADD: {core_d.e, core_d.ac} = sum;
                OP_LDA: core_d.ac = core_q.dr;
                OP_CALL: core_d.pc = core_q.ar;
                OP_INCSKIP: begin
                    core_d.dr = core_q.dr + 1'b1;
                    sc_clr    = 1'b0;
                end
                default: ;
            endcase
        end else if (step[6]) begin
            sc_clr = 1'b1;
            if (op == OP_INCSKIP) begin
                mem_we    = 1'b1;
                mem_wdata = core_q.dr;
                if (core_q.dr == '0) core_d.pc = core_q.pc + 1'b1;
            end
        end else begin
            sc_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign halted = !core_q.run;
    assign dbg_pc = core_q.pc;
    assign dbg_ac = core_q.ac;
    assign dbg_e  = core_q.e;

    // R6
    mem_write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (step[4] || step[6]));

    // R13
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step[3] && (op == OP_EXT) && !core_q.ind && core_q.ir[XB_STOP]) |=> halted);

    // R2
    idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> ($stable(dbg_pc) && $stable(dbg_ac) && halted));

    // R4
    step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step));

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load_we = 1'b0;
    logic [11:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic        halted;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ac;
    logic        dbg_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu_core dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .halted(halted), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_e(dbg_e)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] mm [0:4095];
    logic [11:0] m_pc;
    logic [15:0] m_ac;
    logic        m_e;
    int          m_cyc;
    int          run_cyc;

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_ac = '0; m_e = 1'b0;
    endtask

    // R14: preload port writes one word per cycle
    task automatic put(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        load_we = 1'b1; load_addr = a; load_data = d;
        mm[a] = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic run_prog();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_cyc = 0;
        while (!halted && run_cyc < 5000) begin
            run_cyc++;
            @(negedge clk);
        end
    endtask

    task automatic expect_run(string req, logic [11:0] pc, logic [15:0] ac, logic e, int cyc);
        run_prog();
        check_eq(req, "pc", 32'(dbg_pc), 32'(pc));
        check_eq(req, "ac", 32'(dbg_ac), 32'(ac));
        check_eq(req, "e", 32'(dbg_e), 32'(e));
        check_eq(req, "cycles", 32'(run_cyc), 32'(cyc));
    endtask

    function automatic logic [15:0] mref(int op, bit ind, logic [11:0] a);
        return {ind, op[2:0], a};
    endfunction

    // instruction-level reference following the requirement list
    task automatic model_run();
        logic [15:0] ir;
        logic [11:0] ea;
        logic [15:0] a0;
        logic        e0;
        logic [16:0] s;
        bit          stop;
        int          guard;
        stop = 0; guard = 0; m_cyc = 0;
        while (!stop && guard < 5000) begin
            guard++;
            ir = mm[m_pc];
            m_pc = m_pc + 1'b1;
            ea = ir[11:0];
            if (ir[14:12] == 3'd7) begin
                m_cyc += 4;
                if (!ir[15]) begin
                    a0 = m_ac; e0 = m_e;
                    if (ir[11]) m_ac = '0;
                    if (ir[10]) m_e = 1'b0;
                    if (ir[9])  m_ac = ~m_ac;
                    if (ir[8])  m_e = ~m_e;
                    if (ir[7])  begin s = {m_ac, m_e}; m_ac = {s[0], s[16:2]}; m_e = s[1]; end
                    if (ir[6])  begin s = {m_e, m_ac}; m_e = s[15]; m_ac = {s[14:0], s[16]}; end
                    if (ir[5])  m_ac = m_ac + 1'b1;
                    if ((ir[4] && !a0[15]) || (ir[3] && a0[15]) ||
                        (ir[2] && a0 == 0) || (ir[1] && !e0)) m_pc = m_pc + 1'b1;
                    if (ir[0]) stop = 1;
                end
            end else begin
                if (ir[15]) ea = mm[ea][11:0];
                case (ir[14:12])
                    3'd0: begin m_ac = m_ac & mm[ea]; m_cyc += 6; end
                    3'd1: begin s = {1'b0, m_ac} + {1'b0, mm[ea]}; m_ac = s[15:0]; m_e = s[16]; m_cyc += 6; end
                    3'd2: begin m_ac = mm[ea]; m_cyc += 6; end
                    3'd3: begin mm[ea] = m_ac; m_cyc += 5; end
                    3'd4: begin m_pc = ea; m_cyc += 5; end
                    3'd5: begin mm[ea] = {4'h0, m_pc}; m_pc = ea + 1'b1; m_cyc += 6; end
                    default: begin
                        mm[ea] = mm[ea] + 1'b1;
                        if (mm[ea] == 0) m_pc = m_pc + 1'b1;
                        m_cyc += 7;
                    end
                endcase
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 4096; i++) mm[i] = '0;
        do_reset();
        // R1 reset state
        check_eq("R1", "halted", 32'(halted), 32'd1);
        check_eq("R1", "pc", 32'(dbg_pc), 32'd0);
        check_eq("R1", "ac", 32'(dbg_ac), 32'd0);
        check_eq("R1", "e", 32'(dbg_e), 32'd0);

        // R13 halt alone: 4 cycles, pc after the halt
        put(12'h000, 16'h7001);
        put(12'h001, 16'h7001);
        expect_run("R13", 12'h001, 16'h0000, 1'b0, 4);
        // R2 stays stopped and resumes at pc
        repeat (6) @(negedge clk);
        check_eq("R2", "halted", 32'(halted), 32'd1);
        check_eq("R2", "pc held", 32'(dbg_pc), 32'h1);
        expect_run("R2", 12'h002, 16'h0000, 1'b0, 4);

        // R5 add with carry, R14 preloaded data
        do_reset();
        put(12'h100, 16'hFFFF); put(12'h101, 16'h0002); put(12'h102, 16'h0F0F);
        put(12'h000, mref(2, 0, 12'h100));
        put(12'h001, mref(1, 0, 12'h101));
        put(12'h002, 16'h7001);
        expect_run("R5", 12'h003, 16'h0001, 1'b1, 16);
        // R5 AND keeps the flag
        do_reset();
        put(12'h000, mref(2, 0, 12'h100));
        put(12'h001, mref(0, 0, 12'h102));
        put(12'h002, 16'h7001);
        expect_run("R5", 12'h003, 16'h0F0F, 1'b0, 16);

        // R9 indirect, R4 same cost as direct
        do_reset();
        put(12'h200, 16'h0101);
        put(12'h000, mref(2, 1, 12'h200));
        put(12'h001, 16'h7001);
        expect_run("R9", 12'h002, 16'h0002, 1'b0, 10);

        // R6 store then read back
        do_reset();
        put(12'h000, 16'h7800); put(12'h001, 16'h7200);
        put(12'h002, mref(3, 0, 12'h103)); put(12'h003, 16'h7800);
        put(12'h004, mref(2, 0, 12'h103)); put(12'h005, 16'h7001);
        expect_run("R6", 12'h006, 16'hFFFF, 1'b0, 27);

        // R7 jump
        do_reset();
        put(12'h000, mref(4, 0, 12'h020)); put(12'h020, 16'h7001);
        expect_run("R7", 12'h021, 16'h0000, 1'b0, 9);
        // R7 call, then read back the saved return address
        do_reset();
        put(12'h050, 16'h0000);
        put(12'h000, mref(5, 0, 12'h050)); put(12'h051, 16'h7001);
        expect_run("R7", 12'h052, 16'h0000, 1'b0, 10);
        do_reset();
        put(12'h000, mref(2, 0, 12'h050)); put(12'h001, 16'h7001);
        expect_run("R7", 12'h002, 16'h0001, 1'b0, 10);

        // R8 increment wraps to zero and skips
        do_reset();
        put(12'h104, 16'hFFFF);
        put(12'h000, mref(6, 0, 12'h104)); put(12'h001, 16'h7001);
        put(12'h002, mref(2, 0, 12'h104)); put(12'h003, 16'h7001);
        expect_run("R8", 12'h004, 16'h0000, 1'b0, 17);
        // R8 no skip on nonzero result
        do_reset();
        put(12'h105, 16'h0005);
        put(12'h000, mref(6, 0, 12'h105));
        put(12'h001, mref(2, 0, 12'h105)); put(12'h002, 16'h7001);
        expect_run("R8", 12'h003, 16'h0006, 1'b0, 17);

        // R11 rotate right then left through the flag
        do_reset();
        put(12'h106, 16'h8001);
        put(12'h000, mref(2, 0, 12'h106)); put(12'h001, 16'h7400);
        put(12'h002, 16'h7080); put(12'h003, 16'h7001);
        put(12'h004, 16'h7040); put(12'h005, 16'h7001);
        expect_run("R11", 12'h004, 16'h4000, 1'b1, 18);
        expect_run("R11", 12'h006, 16'h8001, 1'b0, 8);

        // R12 skips
        do_reset();
        put(12'h000, 16'h7800); put(12'h001, 16'h7004); put(12'h002, 16'h7001);
        put(12'h003, 16'h7008); put(12'h004, 16'h7001);
        put(12'h005, 16'h7010); put(12'h006, 16'h7001); put(12'h007, 16'h7400);
        put(12'h008, 16'h7002); put(12'h009, 16'h7001); put(12'h00A, 16'h7001);
        expect_run("R12", 12'h005, 16'h0000, 1'b0, 16);
        expect_run("R12", 12'h00B, 16'h0000, 1'b0, 16);

        // R3 input/output group is a no-op
        do_reset();
        put(12'h000, 16'h7800); put(12'h001, 16'h7200);
        put(12'h002, 16'hF800); put(12'h003, 16'hF080); put(12'h004, 16'h7001);
        expect_run("R3", 12'h005, 16'hFFFF, 1'b0, 20);

        // R10 clear, increment, invert
        do_reset();
        put(12'h000, 16'h7800); put(12'h001, 16'h7020); put(12'h002, 16'h7020);
        put(12'h003, 16'h7100); put(12'h004, 16'h7200); put(12'h005, 16'h7001);
        expect_run("R10", 12'h006, 16'hFFFD, 1'b1, 24);

        // R4 R5 R6 R8 R9 R10 R11 R12: random straight-line programs
        for (int p = 0; p < 20; p++) begin
            do_reset();
            for (int k = 0; k < 16; k++) begin
                put(12'h100 + 12'(k), 16'($urandom));
                put(12'h200 + 12'(k), 16'h0100 + 16'(k));
            end
            for (int n = 0; n < 12; n++) begin
                int sel;
                int k;
                bit ind;
                logic [15:0] w;
                logic [11:0] a;
                sel = $urandom_range(0, 9);
                k   = $urandom_range(0, 15);
                ind = 1'($urandom_range(0, 1));
                a   = ind ? (12'h200 + 12'(k)) : (12'h100 + 12'(k));
                case (sel)
                    0, 1, 2, 3: w = mref(sel, ind, a);
                    4: w = mref(6, ind, a);
                    5, 6, 7: w = 16'h7000 | (16'h1 << $urandom_range(1, 11));
                    8: w = 16'hF000 | (16'h1 << $urandom_range(6, 11));
                    default: w = mref(2, ind, a);
                endcase
                put(12'(n), w);
            end
            put(12'd12, 16'h7001);
            put(12'd13, 16'h7001);
            model_run();
            expect_run("R4", m_pc, m_ac, m_e, m_cyc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule